// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

This block is a chain of static storage stages that moves its contents by one position on every rising clock edge, toward the high end or toward the low end as a direction pin selects. A serial input at each end feeds the stage at that end. A load-select pin chooses whether the end stage takes new serial data or receives the bit that leaves the opposite end, so the whole pattern rotates. A hold pin freezes the contents for any number of edges.

Each end stage drives a serial output through a latch that updates on the falling clock edge. A downstream device sampling on the next rising edge therefore always sees a settled value. This lets several devices be chained into one longer register without a skew hazard. The control pins (direction, load-select, hold) may change only while the clock is low. A clear pin zeroes the stages and both output latches. It exists for initialising simulations and is not part of normal operation.

Top module: `bidir_recirc_shifter`

## Requirements
- R1: With hold=0, load_serial=1 and dir_left=0, a rising edge stores ser_in_right in stage 1 (the low end) and moves every other stage one position toward stage STAGES.
- R2: With hold=0, load_serial=1 and dir_left=1, a rising edge stores ser_in_left in stage STAGES (the high end) and moves every other stage one position toward stage 1.
- R3: With hold=1 and sim_clear=0, a rising edge leaves every stage unchanged, whatever the other control and serial inputs are.
- R4: With hold=0, load_serial=0 and dir_left=0, a rising edge moves stage STAGES into stage 1 and shifts the rest toward the high end. ser_in_right has no effect.
- R5: With hold=0, load_serial=0 and dir_left=1, a rising edge moves stage 1 into stage STAGES and shifts the rest toward the low end. ser_in_left has no effect.
- R6: ser_out_left shows stage 1 and ser_out_right shows stage STAGES. Each output changes only at a falling edge, where it takes the value the stage gained at the rising edge just before, and it holds that value through the next high phase.
- R7: sim_clear=1 at a rising edge zeroes every stage. At a falling edge it zeroes both serial outputs. It takes priority over hold.
- R8: dir_left, load_serial and hold change only while clk is low.
- R9: Two instances chained as follows act as one register of 2*STAGES stages in both directions: the first instance's ser_out_right drives the second's ser_in_right, and the second's ser_out_left drives the first's ser_in_left.
- R10: The stage count is set by the parameter STAGES (default 32, minimum 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Stages update on the rising edge and output latches on the falling edge |
| sim_clear | input | 1 | Synchronous clear of the stages and output latches (simulation initialisation) |
| dir_left | input | 1 | 0 = move toward stage STAGES, 1 = move toward stage 1 |
| load_serial | input | 1 | 1 = the end stage takes the serial input, 0 = recirculate |
| hold | input | 1 | 1 = no shift on the rising edge |
| ser_in_right | input | 1 | Serial data entering stage 1 during a rightward shift |
| ser_in_left | input | 1 | Serial data entering stage STAGES during a leftward shift |
| ser_out_left | output | 1 | Latched copy of stage 1 |
| ser_out_right | output | 1 | Latched copy of stage STAGES |

## Verification
On every rising edge, the assertions check each of the four shift and wrap modes against the stage contents of the previous edge. They also check that hold freezes the array, that clear zeroes it, and that each output latch matches its end stage. Only the bench's scenarios show the following: that a serial input really is ignored while recirculating, that a full 32-bit pattern returns intact after a complete rotation, that two chained instances behave as one 64-stage register, and that the controls never move while the clock is high.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD     = 2'd0,
    OP_SERIAL   = 2'd1,
    OP_WRAP     = 2'd2,
    OP_CLEAR    = 2'd3
  } shr_op_e;
endpackage

// File: rtl/shr_ctrl.sv
module shr_ctrl
  import shr_pkg::*;
(
  input  logic    sim_clear,
  input  logic    hold,
  input  logic    load_serial,
  output shr_op_e op
);
  always_comb begin
    if (sim_clear)        op = OP_CLEAR;
    else if (hold)        op = OP_HOLD;
    else if (load_serial) op = OP_SERIAL;
    else                  op = OP_WRAP;
  end
endmodule

// File: rtl/shr_stage_array.sv
module shr_stage_array
  import shr_pkg::*;
#(
  parameter int STAGES = 32
) (
  input  logic              clk,
  input  shr_op_e           op,
  input  logic              dir_left,
  input  logic              ser_in_right,
  input  logic              ser_in_left,
  output logic [STAGES-1:0] stages
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] nxt;
  logic              head_in;
  logic              tail_in;

  // End feeds: recirculate takes the opposite end's bit.
  assign head_in = (op == OP_WRAP) ? stages[TOP] : ser_in_right;
  assign tail_in = (op == OP_WRAP) ? stages[0]   : ser_in_left;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_first
      assign from_low = head_in;
    end else begin : g_mid_low
      assign from_low = stages[i-1];
    end
    if (i == TOP) begin : g_last
      assign from_high = tail_in;
    end else begin : g_mid_high
      assign from_high = stages[i+1];
    end
    always_comb begin
      unique case (op)
        OP_CLEAR: nxt[i] = 1'b0;
        OP_HOLD:  nxt[i] = stages[i];
        default:  nxt[i] = dir_left ? from_high : from_low;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    stages <= nxt;
  end

  AST_SHIFT_RIGHT_IN: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_SERIAL && !dir_left) |=>
      (stages[0] == $past(ser_in_right)) && (stages[TOP:1] == $past(stages[TOP-1:0]))); // R1
  AST_SHIFT_LEFT_IN: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_SERIAL && dir_left) |=>
      (stages[TOP] == $past(ser_in_left)) && (stages[TOP-1:0] == $past(stages[TOP:1]))); // R2
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_HOLD) |=> $stable(stages)); // R3
  AST_WRAP_RIGHT: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_WRAP && !dir_left) |=>
      (stages == {$past(stages[TOP-1:0]), $past(stages[TOP])})); // R4
  AST_WRAP_LEFT: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_WRAP && dir_left) |=>
      (stages == {$past(stages[0]), $past(stages[TOP:1])})); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk)
    (op == OP_CLEAR) |=> (stages == '0)); // R7
endmodule

// File: rtl/shr_out_latch.sv
module shr_out_latch (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  // Updates on the falling edge so a chained neighbour samples a settled bit.
  always_ff @(negedge clk) begin
    if (clr) q <= 1'b0;
    else     q <= d;
  end

  AST_OUT_CLEARED: assert property (@(negedge clk)
    clr |=> (q == 1'b0)); // R7
endmodule

// File: rtl/bidir_recirc_shifter.sv
module bidir_recirc_shifter
  import shr_pkg::*;
#(
  parameter int STAGES = 32
) (
  input  logic clk,
  input  logic sim_clear,
  input  logic dir_left,
  input  logic load_serial,
  input  logic hold,
  input  logic ser_in_right,
  input  logic ser_in_left,
  output logic ser_out_left,
  output logic ser_out_right
);
  localparam int TOP = STAGES - 1;

  shr_op_e           op;
  logic [STAGES-1:0] stages;

  initial begin
    if (STAGES < 2) $error("STAGES must be at least 2"); // R10
  end

  shr_ctrl u_ctrl (
    .sim_clear   (sim_clear),
    .hold        (hold),
    .load_serial (load_serial),
    .op          (op)
  );

  shr_stage_array #(.STAGES(STAGES)) u_array (
    .clk          (clk),
    .op           (op),
    .dir_left     (dir_left),
    .ser_in_right (ser_in_right),
    .ser_in_left  (ser_in_left),
    .stages       (stages)
  );

  shr_out_latch u_lat_left (
    .clk (clk),
    .clr (sim_clear),
    .d   (stages[0]),
    .q   (ser_out_left)
  );

  shr_out_latch u_lat_right (
    .clk (clk),
    .clr (sim_clear),
    .d   (stages[TOP]),
    .q   (ser_out_right)
  );

  // At a rising edge, before the array moves, the latches hold the end stages.
  AST_OUT_LEFT_TRACKS: assert property (@(posedge clk) disable iff (sim_clear)
    $past(!sim_clear) |-> (ser_out_left == stages[0])); // R6
  AST_OUT_RIGHT_TRACKS: assert property (@(posedge clk) disable iff (sim_clear)
    $past(!sim_clear) |-> (ser_out_right == stages[TOP])); // R6
endmodule

// File: tb/sim_bidir_recirc_shifter.sv
module sim_bidir_recirc_shifter;
  localparam int N = 32;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic dl = 1'b0, ld = 1'b1, hd = 1'b0, sr = 1'b0, sl = 1'b0;
  logic chain = 1'b0;
  logic o_l, o_r, o1_l, o1_r, u0_sl;
  int   checks = 0, fails = 0, proto_viol = 0;
  bit   done = 1'b0;
  logic [N-1:0]   rq;
  logic [2*N-1:0] rq64;

  always #10 clk = ~clk; // 50 MHz

  assign u0_sl = chain ? o1_l : sl;

  bidir_recirc_shifter #(.STAGES(N)) u0 (
    .clk(clk), .sim_clear(clr), .dir_left(dl), .load_serial(ld), .hold(hd),
    .ser_in_right(sr), .ser_in_left(u0_sl),
    .ser_out_left(o_l), .ser_out_right(o_r));

  bidir_recirc_shifter #(.STAGES(N)) u1 (
    .clk(clk), .sim_clear(clr), .dir_left(dl), .load_serial(ld), .hold(hd),
    .ser_in_right(o_r), .ser_in_left(sl),
    .ser_out_left(o1_l), .ser_out_right(o1_r));

  // R8 protocol monitor: controls must not move while clk is high
  always @(dl or ld or hd) if (clk === 1'b1) proto_viol++;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: entered just after a falling edge.
  task automatic step(input logic d, input logic l, input logic h,
                      input logic s_r, input logic s_l, input string tag);
    logic ol, orr;
    dl = d; ld = l; hd = h; sr = s_r; sl = s_l;
    ol = rq[0]; orr = rq[N-1];
    @(posedge clk); #1;
    chk(o_l, ol, "R6 left held in high phase");
    chk(o_r, orr, "R6 right held in high phase");
    if (!h) begin
      if (!d) rq = {rq[N-2:0], l ? s_r : rq[N-1]};
      else    rq = {l ? s_l : rq[0], rq[N-1:1]};
    end
    @(negedge clk); #1;
    chk(o_l, rq[0], {tag, " left out"});
    chk(o_r, rq[N-1], {tag, " right out"});
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    clr = 1'b0;
    rq = '0;
    chk(o_l, 1'b0, "R7 clear left");
    chk(o_r, 1'b0, "R7 clear right");
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk); #1;
    chk(o_l, 1'b0, "R7 reset left");
    chk(o_r, 1'b0, "R7 reset right");
    clr = 1'b0; rq = '0;
  endtask

  task automatic t_shift_right();
    logic [N-1:0] pat = 32'hA5C3_1E07;
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, pat[i], 1'b1, "R1 shift right");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1 shift right drain");
  endtask

  task automatic t_shift_left();
    logic [N-1:0] pat = 32'h3C96_F00D;
    for (int i = 0; i < N; i++) step(1'b1, 1'b1, 1'b0, 1'b0, pat[i], "R2 shift left");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 5; i++) step(i[0], i[1], 1'b1, ~i[0], i[0], "R3 hold");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 release");
  endtask

  task automatic t_wrap_right();
    for (int i = 0; i < N + 3; i++) step(1'b0, 1'b0, 1'b0, i[0], i[1], "R4 wrap right");
  endtask

  task automatic t_wrap_left();
    for (int i = 0; i < N + 3; i++) step(1'b1, 1'b0, 1'b0, ~i[0], i[2], "R5 wrap left");
  endtask

  task automatic t_clear_over_hold();
    hd = 1'b1;
    do_clear();
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R7 cleared array stays zero");
  endtask

  // Entered after a falling edge with both instances cleared.
  task automatic chain_step(input logic d, input logic s_r, input logic s_l);
    dl = d; ld = 1'b1; hd = 1'b0; sr = s_r; sl = s_l;
    @(posedge clk);
    if (!d) rq64 = {rq64[2*N-2:0], s_r};
    else    rq64 = {s_l, rq64[2*N-1:1]};
    @(negedge clk); #1;
    chk(o_l,  rq64[0],     "R9 chain first-stage out");
    chk(o1_r, rq64[2*N-1], "R9 chain last-stage out");
  endtask

  task automatic t_cascade();
    do_clear();
    rq64 = '0;
    chain = 1'b1;
    for (int i = 0; i < 2*N + 4; i++) chain_step(1'b0, i[0] ^ i[3], 1'b0);
    for (int i = 0; i < 2*N + 4; i++) chain_step(1'b1, 1'b0, i[1] ^ i[4]);
    chain = 1'b0;
  endtask

  initial begin
    t_reset();
    t_shift_right();
    t_hold();
    t_shift_left();
    t_wrap_right();
    t_wrap_left();
    t_clear_over_hold();
    do_clear();
    t_shift_right();
    t_cascade();
    checks++;
    if (proto_viol != 0) begin
      fails++;
      $display("FAIL R8 control changed while clk high actual=%0d expected=0", proto_viol);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule